// File: doc/BRIEF.md
# Dual-CPU Power Mode Arbiter

This block decides, every clock, what operating mode each of two logic domains and the shared system domain should be in. Each domain belongs to one of two CPUs, so domain 0 goes with CPU 0 and domain 1 goes with CPU 1. A domain keeps running while its own CPU needs it, or while the other CPU needs it because that CPU owns a peripheral there. When nobody needs the domain, the two CPUs' deep-power-down votes choose between stop and standby.

The system domain stays up while either CPU is awake or any wakeup line is raised. After reset, and again after leaving standby, it runs in a limited-performance phase until the voltage-ready flag is seen.

Every mode is registered. The matching clock enables are registered once more, one cycle behind the mode, so an enable never changes in the same cycle as the mode that drives it. There are enables for each domain's bus matrix, for the system bus, and for each CPU's core clock and peripheral clocks.

Top module: `pwr_mode_arbiter`

## Requirements
- R1: After a synchronous active-high reset, both domain modes read run (00), the system mode reads limited run (00), and every clock enable reads 1.
- R2: CPU mode encoding is 00 run, 01 sleep, 10 or 11 stop. A domain mode (00 run, 01 stop, 10 standby) is run when its own CPU is in run or sleep. It is also run when the other CPU is in run or sleep and that CPU's ownership flag for the domain (xown_i bit d) is 1.
- R3: Otherwise the domain is in stop if either of its two select bits is 0. The select bit of CPU c for domain d is sel_i[c*2+d], where 1 votes standby and 0 votes stop.
- R4: Otherwise, when both of the domain's select bits are 1, the domain mode is standby.
- R5: System mode encoding is 00 limited run, 01 run, 10 stop, 11 standby. While any CPU is in run or sleep, or any wakeup line is high, the system leaves limited run or run only toward run.
- R6: From limited run or run, with both CPUs stopped and no wakeup line high, the system enters stop if any of the four select bits is 0. It stays in stop until awakened.
- R7: Under the same quiet condition, if all four select bits are 1 the system enters standby. It stays in standby until awakened.
- R8: Limited run holds while the system is awake and vos_rdy_i samples 0. It becomes run at the first edge where vos_rdy_i is 1 while awake. Waking from standby returns the system to limited run.
- R9: A wakeup line high while the system is in stop returns the system to run at the next clock edge.
- R10: Domain and system modes change one edge after their inputs. dom_bus_en_o[d] follows "domain d is in run" one edge later. sys_bus_en_o follows "system is in limited run or run" one edge later.
- R11: cpu_core_en_o[c] is 1 only when CPU c is in run. cpu_per_en_o[c] is 0 only when CPU c is in stop. Both enables change two edges after the CPU mode input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_mode_i | input | 4 | CPU c mode at bits [2c+1:2c] |
| xown_i | input | 2 | Bit d: the CPU not owning domain d holds a peripheral in it |
| sel_i | input | 4 | Deep-power-down votes, bit c*2+d |
| wake_i | input | N_WAKE | Wakeup request lines |
| vos_rdy_i | input | 1 | Voltage scaling ready |
| dom_mode_o | output | 4 | Domain d mode at bits [2d+1:2d] |
| sys_mode_o | output | 2 | System mode |
| dom_bus_en_o | output | 2 | Domain bus matrix clock enables |
| sys_bus_en_o | output | 1 | System bus clock enable |
| cpu_core_en_o | output | 2 | CPU core clock enables |
| cpu_per_en_o | output | 2 | CPU peripheral clock enables |

## Verification
A wakeup line can rise in the same cycle that the last awake CPU enters stop. In that cycle the domain logic lets the domain fall to stop, while the system logic must keep the system running. The bench drives both CPUs to stop with a wakeup line already high. It then checks that the domains report stop while the system stays in run and its bus enable stays on. A reference model in the bench steps on every edge and judges the whole input sweep, including wakeups raised during stop and standby.

// File: rtl/pmarb_pkg.sv
package pmarb_pkg;
  localparam int NCPU = 2;
  localparam int NDOM = NCPU;

  typedef enum logic [1:0] {DM_RUN = 2'b00, DM_STOP = 2'b01, DM_STBY = 2'b10} dom_mode_t;
  typedef enum logic [1:0] {SM_LRUN = 2'b00, SM_RUN = 2'b01, SM_STOP = 2'b10, SM_STBY = 2'b11} sys_mode_t;

  localparam logic [1:0] CM_RUN = 2'b00;
endpackage

// File: rtl/pmarb_dom_eval.sv
module pmarb_dom_eval
  import pmarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       own_act,
  input  logic       oth_act,
  input  logic       oth_owns,
  input  logic       sel_own,
  input  logic       sel_oth,
  output logic [1:0] mode_o
);
  dom_mode_t nxt, q;
  logic      may_leave;

  always_comb begin
    may_leave = !own_act && (!oth_owns || !oth_act);
    if (!may_leave)             nxt = DM_RUN;
    else if (sel_own && sel_oth) nxt = DM_STBY;
    else                         nxt = DM_STOP;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= DM_RUN;
    else     q <= nxt;
  end

  assign mode_o = q;

  // R2: a needed domain is running one edge later
  a_r2_needed_runs: assert property (@(posedge clk) disable iff (rst)
    (own_act || (oth_act && oth_owns)) |=> (q == DM_RUN));
  // R3: a mixed vote gives stop
  a_r3_mixed_stop: assert property (@(posedge clk) disable iff (rst)
    (!own_act && !(oth_act && oth_owns) && !(sel_own && sel_oth)) |=> (q == DM_STOP));
  // R4: standby only after a unanimous vote
  a_r4_stby_vote: assert property (@(posedge clk) disable iff (rst)
    (q == DM_STBY) |-> $past(sel_own && sel_oth));
endmodule

// File: rtl/pmarb_sys_fsm.sv
module pmarb_sys_fsm
  import pmarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       any_act,
  input  logic       wake_any,
  input  logic       all_stby,
  input  logic       vos_rdy,
  output logic [1:0] mode_o
);
  sys_mode_t q, nxt;
  logic      quiet;
  sys_mode_t sleep_tgt;

  always_comb begin
    quiet     = !any_act && !wake_any;
    sleep_tgt = all_stby ? SM_STBY : SM_STOP;
    nxt       = q;
    unique case (q)
      SM_LRUN: nxt = quiet ? sleep_tgt : (vos_rdy ? SM_RUN : SM_LRUN);
      SM_RUN:  nxt = quiet ? sleep_tgt : SM_RUN;
      SM_STOP: nxt = quiet ? SM_STOP : SM_RUN;
      SM_STBY: nxt = quiet ? SM_STBY : SM_LRUN;
      default: nxt = SM_LRUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= SM_LRUN;
    else     q <= nxt;
  end

  assign mode_o = q;

  // R5: awake demand keeps the system in a running mode
  a_r5_awake_runs: assert property (@(posedge clk) disable iff (rst)
    (!quiet && (q == SM_LRUN || q == SM_RUN)) |=> (q == SM_LRUN || q == SM_RUN));
  // R7: standby entry needs quiet and a unanimous vote
  a_r7_stby_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(q == SM_STBY) |-> $past(quiet && all_stby));
  // R8: limited run holds without voltage ready
  a_r8_lrun_hold: assert property (@(posedge clk) disable iff (rst)
    (q == SM_LRUN && !quiet && !vos_rdy) |=> (q == SM_LRUN));
  // R8: standby exits into limited run
  a_r8_stby_exit: assert property (@(posedge clk) disable iff (rst)
    (q == SM_STBY && !quiet) |=> (q == SM_LRUN));
  // R9: wakeup in stop returns to run
  a_r9_wake_stop: assert property (@(posedge clk) disable iff (rst)
    (q == SM_STOP && wake_any) |=> (q == SM_RUN));
endmodule

// File: rtl/pmarb_clk_gate.sv
module pmarb_clk_gate
  import pmarb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NDOM-1:0] dom_mode_i,
  input  logic [1:0]        sys_mode_i,
  input  logic [2*NCPU-1:0] cpu_mode_i,
  output logic [NDOM-1:0]   dom_en_o,
  output logic              sys_en_o,
  output logic [NCPU-1:0]   core_en_o,
  output logic [NCPU-1:0]   per_en_o
);
  logic [2*NCPU-1:0] cm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_q     <= '0;
      sys_en_o <= 1'b1;
    end else begin
      cm_q     <= cpu_mode_i;
      sys_en_o <= (sys_mode_i == SM_LRUN) || (sys_mode_i == SM_RUN);
    end
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    always_ff @(posedge clk) begin
      if (rst) dom_en_o[d] <= 1'b1;
      else     dom_en_o[d] <= (dom_mode_i[2*d+:2] == DM_RUN);
    end
    // R10: enable drops one edge after the domain leaves run
    a_r10_dom_off: assert property (@(posedge clk) disable iff (rst)
      (dom_mode_i[2*d+:2] != DM_RUN) |=> !dom_en_o[d]);
    a_r10_dom_on: assert property (@(posedge clk) disable iff (rst)
      $rose(dom_en_o[d]) |-> $past(dom_mode_i[2*d+:2] == DM_RUN));
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) begin
        core_en_o[c] <= 1'b1;
        per_en_o[c]  <= 1'b1;
      end else begin
        core_en_o[c] <= (cm_q[2*c+:2] == CM_RUN);
        per_en_o[c]  <= !cm_q[2*c+1];
      end
    end
    // R11: a stopped CPU loses peripheral clocks two edges later
    a_r11_stop_gates: assert property (@(posedge clk) disable iff (rst)
      cpu_mode_i[2*c+1] |=> ##1 !per_en_o[c]);
    // R11: core clock stays off unless in run
    a_r11_core_run: assert property (@(posedge clk) disable iff (rst)
      (cpu_mode_i[2*c+:2] != CM_RUN) |=> ##1 !core_en_o[c]);
  end

  // R10: system bus enable returns only after a running mode
  a_r10_sys_on: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_en_o) |-> $past(sys_mode_i == SM_LRUN || sys_mode_i == SM_RUN));
endmodule

// File: rtl/pwr_mode_arbiter.sv
module pwr_mode_arbiter
  import pmarb_pkg::*;
#(
  parameter int N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NCPU-1:0] cpu_mode_i,
  input  logic [NDOM-1:0]   xown_i,
  input  logic [NCPU*NDOM-1:0] sel_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic              vos_rdy_i,
  output logic [2*NDOM-1:0] dom_mode_o,
  output logic [1:0]        sys_mode_o,
  output logic [NDOM-1:0]   dom_bus_en_o,
  output logic              sys_bus_en_o,
  output logic [NCPU-1:0]   cpu_core_en_o,
  output logic [NCPU-1:0]   cpu_per_en_o
);
  logic [NCPU-1:0] act;
  logic            wake_any;
  logic            all_stby;

  for (genvar c = 0; c < NCPU; c++) begin : g_act
    assign act[c] = !cpu_mode_i[2*c+1];
  end

  assign wake_any = |wake_i;
  assign all_stby = &sel_i;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    localparam int OTH = NCPU - 1 - d;
    pmarb_dom_eval u_dom (
      .clk      (clk),
      .rst      (rst),
      .own_act  (act[d]),
      .oth_act  (act[OTH]),
      .oth_owns (xown_i[d]),
      .sel_own  (sel_i[d*NDOM+d]),
      .sel_oth  (sel_i[OTH*NDOM+d]),
      .mode_o   (dom_mode_o[2*d+:2])
    );
  end

  pmarb_sys_fsm u_sys (
    .clk      (clk),
    .rst      (rst),
    .any_act  (|act),
    .wake_any (wake_any),
    .all_stby (all_stby),
    .vos_rdy  (vos_rdy_i),
    .mode_o   (sys_mode_o)
  );

  pmarb_clk_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .dom_mode_i (dom_mode_o),
    .sys_mode_i (sys_mode_o),
    .cpu_mode_i (cpu_mode_i),
    .dom_en_o   (dom_bus_en_o),
    .sys_en_o   (sys_bus_en_o),
    .core_en_o  (cpu_core_en_o),
    .per_en_o   (cpu_per_en_o)
  );

  // R6: stop entry only when both CPUs are stopped and wakeups are low
  a_r6_stop_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_mode_o == SM_STOP) |-> $past(!(|act) && !wake_any && !all_stby));
endmodule

// File: tb/sim_pwr_mode_arbiter.sv
`timescale 1ns/1ps
module sim_pwr_mode_arbiter;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] cpu_mode_i;
  logic [1:0] xown_i;
  logic [3:0] sel_i;
  logic [3:0] wake_i;
  logic       vos_rdy_i;
  logic [3:0] dom_mode_o;
  logic [1:0] sys_mode_o;
  logic [1:0] dom_bus_en_o;
  logic       sys_bus_en_o;
  logic [1:0] cpu_core_en_o;
  logic [1:0] cpu_per_en_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwr_mode_arbiter #(.N_WAKE(4)) u0 (
    .clk(clk), .rst(rst), .cpu_mode_i(cpu_mode_i), .xown_i(xown_i), .sel_i(sel_i),
    .wake_i(wake_i), .vos_rdy_i(vos_rdy_i), .dom_mode_o(dom_mode_o), .sys_mode_o(sys_mode_o),
    .dom_bus_en_o(dom_bus_en_o), .sys_bus_en_o(sys_bus_en_o),
    .cpu_core_en_o(cpu_core_en_o), .cpu_per_en_o(cpu_per_en_o)
  );

  // reference model state
  logic [1:0] m_dom [2];
  logic [1:0] m_sys;
  logic [1:0] m_domen;
  logic       m_sysen;
  logic [1:0] m_cmq [2];
  logic [1:0] m_core, m_per;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic awake(input logic [1:0] m);
    return !m[1];
  endfunction

  function automatic logic [1:0] dom_ref(input int d);
    logic [1:0] own, oth;
    logic so, st;
    own = cpu_mode_i[2*d+:2];
    oth = cpu_mode_i[2*(1-d)+:2];
    so  = sel_i[d*2+d];
    st  = sel_i[(1-d)*2+d];
    if (awake(own) || (awake(oth) && xown_i[d])) return 2'b00;
    if (so && st) return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [1:0] sys_ref(input logic [1:0] s);
    logic quiet;
    quiet = !awake(cpu_mode_i[1:0]) && !awake(cpu_mode_i[3:2]) && (wake_i == 0);
    case (s)
      2'b00: return quiet ? ((&sel_i) ? 2'b11 : 2'b10) : (vos_rdy_i ? 2'b01 : 2'b00);
      2'b01: return quiet ? ((&sel_i) ? 2'b11 : 2'b10) : 2'b01;
      2'b10: return quiet ? 2'b10 : 2'b01;
      default: return quiet ? 2'b11 : 2'b00;
    endcase
  endfunction

  task automatic model_reset();
    m_dom[0] = 0; m_dom[1] = 0; m_sys = 0; m_domen = 2'b11; m_sysen = 1;
    m_cmq[0] = 0; m_cmq[1] = 0; m_core = 2'b11; m_per = 2'b11;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model_reset();
    else begin
      for (int d = 0; d < 2; d++) m_domen[d] = (m_dom[d] == 2'b00);
      m_sysen = (m_sys == 2'b00) || (m_sys == 2'b01);
      for (int c = 0; c < 2; c++) begin
        m_core[c] = (m_cmq[c] == 2'b00);
        m_per[c]  = !m_cmq[c][1];
      end
      m_cmq[0] = cpu_mode_i[1:0];
      m_cmq[1] = cpu_mode_i[3:2];
      m_dom[0] = dom_ref(0);
      m_dom[1] = dom_ref(1);
      m_sys    = sys_ref(m_sys);
    end
    @(negedge clk);
  endtask

  task automatic compare();
    chk("R2 R3 R4 dom0 mode", dom_mode_o[1:0], m_dom[0]);
    chk("R2 R3 R4 dom1 mode", dom_mode_o[3:2], m_dom[1]);
    chk("R5 R6 R7 R8 R9 sys mode", sys_mode_o, m_sys);
    chk("R10 domain bus enables", dom_bus_en_o, m_domen);
    chk("R10 system bus enable", sys_bus_en_o, m_sysen);
    chk("R11 core enables", cpu_core_en_o, m_core);
    chk("R11 peripheral enables", cpu_per_en_o, m_per);
  endtask

  task automatic drive(input logic [3:0] cm, input logic [1:0] xo, input logic [3:0] sl,
                       input logic [3:0] wk, input logic vr);
    cpu_mode_i = cm; xown_i = xo; sel_i = sl; wake_i = wk; vos_rdy_i = vr;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(4'b0000, 2'b00, 4'b0000, 4'b0000, 1'b0);
    model_reset();
    do_reset();
    // R1: reset state
    chk("R1 dom modes after reset", dom_mode_o, 0);
    chk("R1 sys mode after reset", sys_mode_o, 0);
    chk("R1 enables after reset", {dom_bus_en_o, sys_bus_en_o, cpu_core_en_o, cpu_per_en_o}, 7'h7f);

    // R8: limited run holds while voltage ready is low
    for (int k = 0; k < 5; k++) begin
      step(); compare();
    end
    chk("R8 limited run hold", sys_mode_o, 0);
    drive(4'b0000, 2'b00, 4'b0000, 4'b0000, 1'b1);
    step(); compare();
    chk("R8 run after ready", sys_mode_o, 1);

    // exhaustive sweep of modes, ownership, votes and wakeups
    for (int i = 0; i < 2048; i++) begin
      drive(i[3:0], i[5:4], i[9:6], i[10] ? (4'b0001 << (i % 4)) : 4'b0000, 1'b1);
      step(); compare();
      step(); compare();
    end

    // R6 and R9: stop then wakeup
    drive(4'b0000, 2'b00, 4'b0000, 4'b0000, 1'b1);
    step(); step(); compare();
    drive(4'b1010, 2'b11, 4'b1011, 4'b0000, 1'b1);
    step(); compare();
    chk("R6 stop entry", sys_mode_o, 2);
    chk("R3 dom0 stop on mixed vote", dom_mode_o[1:0], 1);
    chk("R4 dom1 standby on unanimous vote", dom_mode_o[3:2], 2);
    step(); compare();
    chk("R10 system bus off in stop", sys_bus_en_o, 0);
    drive(4'b1010, 2'b11, 4'b1011, 4'b0100, 1'b1);
    step(); compare();
    chk("R9 wake from stop to run", sys_mode_o, 1);
    step(); compare();
    chk("R9 R10 system bus back on", sys_bus_en_o, 1);

    // R7 and R8: standby and return through limited run
    drive(4'b1110, 2'b00, 4'b1111, 4'b0000, 1'b0);
    step(); compare();
    chk("R7 standby entry", sys_mode_o, 3);
    step(); compare();
    drive(4'b1110, 2'b00, 4'b1111, 4'b1000, 1'b0);
    step(); compare();
    chk("R8 standby exit to limited run", sys_mode_o, 0);
    step(); step(); compare();
    chk("R8 limited run held without ready", sys_mode_o, 0);
    drive(4'b1110, 2'b00, 4'b1111, 4'b1000, 1'b1);
    step(); compare();
    chk("R8 ready gives run", sys_mode_o, 1);

    // R5: last CPU stops in the same cycle a wakeup line is high
    drive(4'b0100, 2'b00, 4'b0000, 4'b0000, 1'b1);
    step(); step(); compare();
    drive(4'b1010, 2'b00, 4'b0000, 4'b0010, 1'b1);
    step(); compare();
    chk("R5 system stays run with wakeup", sys_mode_o, 1);
    chk("R3 domains stop meanwhile", dom_mode_o, 4'b0101);
    step(); compare();
    chk("R5 system bus stays on", sys_bus_en_o, 1);
    chk("R11 core clocks off", cpu_core_en_o, 0);
    chk("R11 peripheral clocks off", cpu_per_en_o, 0);
    // R2: sleeping owner keeps the foreign domain running
    drive(4'b0110, 2'b01, 4'b1111, 4'b0000, 1'b1);
    step(); compare();
    chk("R2 foreign owner keeps dom0 run", dom_mode_o[1:0], 0);
    chk("R2 own sleep keeps dom1 run", dom_mode_o[3:2], 0);
    step(); step(); compare();
    chk("R11 sleep keeps peripheral clock", cpu_per_en_o, 2'b10);
    chk("R11 sleep gates core clock", cpu_core_en_o, 2'b00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule